// File: doc/BRIEF.md
# Channelized Digital Clock Synthesizer

This block derives a clock-like square wave and a matching one-cycle strobe from a single fixed master clock. The target rate is picked at run time from a grid of 21 channels, 8.0 MHz to 10.0 MHz in 100 kHz steps. A downstream demodulator uses either the square wave or, more commonly, the strobe as a clock enable in the master domain.

Two engines are available. The first is a 32-bit phase accumulator. Its average rate matches the target closely, but each individual period is either one or the other of two adjacent integer lengths. The second is an integer divider. Its period is an exact whole number of master cycles, and a half-count compare shapes the duty cycle. The per-channel constants for both engines are computed at elaboration from the master frequency parameter. A change of channel or engine is held in a shadow stage and applied only at the next period boundary, so no shortened pulse is emitted.

Top module: `chan_clk_synth`

## Requirements
- R1: Channel index k (0..20) selects a target frequency f = 8.0 MHz + k x 100 kHz; with the default 100 MHz master, the strobe count over any window of W master cycles is within one of W x f / 100 MHz in accumulator mode.
- R2: In accumulator mode (mode_sel = 0) a 32-bit accumulator adds round(f x 2^32 / f_master) every master cycle; synth_out is the accumulator MSB and synth_stb pulses for one cycle after each carry out.
- R3: In accumulator mode every strobe-to-strobe interval is floor(2^32 / tw) or that value plus one master cycle, where tw is the tuning word of R2.
- R4: In divider mode (mode_sel = 1) the strobe-to-strobe interval is exactly D = round(f_master / f) master cycles (D = 13 for channel 0, D = 10 for channel 20 at 100 MHz).
- R5: In divider mode synth_out is high for the first floor(D / 2) cycles of each period and low for the rest.
- R6: A channel change takes effect only at the next period boundary; the period in progress completes with the old length.
- R7: A mode change also waits for the period boundary, and the new engine then starts from zero phase.
- R8: A channel index above 20 acts as channel 20.
- R9: chan_err is set by any channel index above 20 and stays set until reset.
- R10: While rst_n is low, synth_out, synth_stb and chan_err are low. After reset the block runs channel 0 in accumulator mode.
- R11: synth_stb is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| chan_sel | input | 5 | Requested channel index |
| mode_sel | input | 1 | Engine select: 0 accumulator, 1 divider |
| synth_out | output | 1 | Synthesized clock-like square wave |
| synth_stb | output | 1 | One-cycle strobe per output period |
| chan_err | output | 1 | Sticky flag for an out-of-range channel index |

## Verification
On every cycle the assertions check four things:
- the strobe is never longer than a single cycle;
- the active configuration changes only in a cycle that follows a period boundary;
- the active channel stays within the table and the error flag stays set once raised;
- the divider count stays inside its period, and the accumulator MSB is low right after a carry.

Some behaviour can only be shown by the bench scenarios, because it depends on arithmetic across many cycles. These scenarios cover:
- the average rate of each channel against its target;
- the exact divider period and high time on every channel;
- the one-cycle period spread of the accumulator;
- the old period completing before a channel or mode switch takes effect.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;

  typedef enum logic {
    MODE_ACC = 1'b0,
    MODE_DIV = 1'b1
  } synth_mode_e;

  // Target frequency of a grid channel in Hz.
  function automatic longint unsigned grid_hz(longint unsigned base_hz,
                                              longint unsigned step_hz,
                                              int unsigned idx);
    return base_hz + step_hz * 64'(idx);
  endfunction

  // Rounded phase increment for an accumulator of acc_w bits.
  function automatic longint unsigned tune_word(longint unsigned master_hz,
                                                longint unsigned f_hz,
                                                int unsigned acc_w);
    return ((f_hz << acc_w) + master_hz / 2) / master_hz;
  endfunction

  // Rounded integer division ratio.
  function automatic longint unsigned div_ratio(longint unsigned master_hz,
                                                longint unsigned f_hz);
    return (master_hz + f_hz / 2) / f_hz;
  endfunction

endpackage

// File: rtl/clksyn_table.sv
module clksyn_table
  import clksyn_pkg::*;
#(
  parameter longint unsigned MASTER_HZ = 64'd100_000_000,
  parameter longint unsigned BASE_HZ   = 64'd8_000_000,
  parameter longint unsigned STEP_HZ   = 64'd100_000,
  parameter int              NUM_CH    = 21,
  parameter int              CH_W      = 5,
  parameter int              ACC_W     = 32,
  parameter int              DIV_W     = 16
) (
  input  logic [CH_W-1:0]  ch,
  output logic [ACC_W-1:0] tw,
  output logic [DIV_W-1:0] div,
  output logic [DIV_W-1:0] half
);

  localparam int ROWS = 1 << CH_W;

  logic [ACC_W-1:0] tw_rom   [ROWS];
  logic [DIV_W-1:0] div_rom  [ROWS];
  logic [DIV_W-1:0] half_rom [ROWS];

  // Rows past the last channel repeat the top channel.
  for (genvar i = 0; i < ROWS; i++) begin : g_row
    localparam int unsigned     IDX = (i < NUM_CH) ? i : NUM_CH - 1;
    localparam longint unsigned FHZ = grid_hz(BASE_HZ, STEP_HZ, IDX);
    localparam longint unsigned DV  = div_ratio(MASTER_HZ, FHZ);
    assign tw_rom[i]   = ACC_W'(tune_word(MASTER_HZ, FHZ, ACC_W));
    assign div_rom[i]  = DIV_W'(DV);
    assign half_rom[i] = DIV_W'(DV / 2);
  end

  assign tw   = tw_rom[ch];
  assign div  = div_rom[ch];
  assign half = half_rom[ch];

endmodule

// File: rtl/clksyn_acc.sv
module clksyn_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             leave,
  input  logic [ACC_W-1:0] tw,
  output logic             msb,
  output logic             carry
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, tw};
    carry = run & sum[ACC_W];
    if (!run)
      acc_d = '0;
    else if (carry && leave)
      acc_d = '0;
    else
      acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign msb = acc_q[ACC_W-1];

  // R2: after a wrap the residue is below the step, so the MSB is low
  p_wrap_msb_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> !msb);

endmodule

// File: rtl/clksyn_div.sv
module clksyn_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic [DIV_W-1:0] half,
  output logic             out,
  output logic             tc
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tc = run & (cnt_q == div - DIV_W'(1));
    if (!run || tc) cnt_d = '0;
    else            cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign out = run & (cnt_q < half);

  // R4: the count never leaves its period
  p_cnt_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < div));

endmodule

// File: rtl/chan_clk_synth.sv
module chan_clk_synth
  import clksyn_pkg::*;
#(
  parameter longint unsigned MASTER_HZ = 64'd100_000_000,
  parameter longint unsigned BASE_HZ   = 64'd8_000_000,
  parameter longint unsigned STEP_HZ   = 64'd100_000,
  parameter int              NUM_CH    = 21,
  parameter int              CH_W      = 5,
  parameter int              ACC_W     = 32,
  parameter int              DIV_W     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] chan_sel,
  input  logic            mode_sel,
  output logic            synth_out,
  output logic            synth_stb,
  output logic            chan_err
);

  localparam logic [CH_W-1:0] CH_MAX = CH_W'(NUM_CH - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // Shadow (requested) and active configuration.
  logic [CH_W-1:0] ch_sh_q, ch_sh_d, ch_q, ch_d;
  synth_mode_e     mode_sh_q, mode_sh_d, mode_q, mode_d;
  logic            err_q, err_d, stb_q;
  logic            bnd, over;

  logic [ACC_W-1:0] tw;
  logic [DIV_W-1:0] div, half;
  logic             acc_msb, acc_carry, div_out, div_tc;
  logic             acc_run, div_run;

  assign acc_run = (mode_q == MODE_ACC);
  assign div_run = (mode_q == MODE_DIV);
  assign bnd     = acc_carry | div_tc;

  always_comb begin
    over      = (chan_sel > CH_MAX);
    ch_sh_d   = over ? CH_MAX : chan_sel;
    mode_sh_d = synth_mode_e'(mode_sel);
    err_d     = err_q | over;
    ch_d      = bnd ? ch_sh_q   : ch_q;
    mode_d    = bnd ? mode_sh_q : mode_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ch_sh_q   <= '0;
      mode_sh_q <= MODE_ACC;
      ch_q      <= '0;
      mode_q    <= MODE_ACC;
      err_q     <= 1'b0;
      stb_q     <= 1'b0;
    end else begin
      ch_sh_q   <= ch_sh_d;
      mode_sh_q <= mode_sh_d;
      ch_q      <= ch_d;
      mode_q    <= mode_d;
      err_q     <= err_d;
      stb_q     <= bnd;
    end
  end

  clksyn_table #(
    .MASTER_HZ(MASTER_HZ), .BASE_HZ(BASE_HZ), .STEP_HZ(STEP_HZ),
    .NUM_CH(NUM_CH), .CH_W(CH_W), .ACC_W(ACC_W), .DIV_W(DIV_W)
  ) u_table (
    .ch(ch_q), .tw(tw), .div(div), .half(half)
  );

  clksyn_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_s), .run(acc_run),
    .leave(mode_sh_q != MODE_ACC), .tw(tw),
    .msb(acc_msb), .carry(acc_carry)
  );

  clksyn_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_s), .run(div_run),
    .div(div), .half(half), .out(div_out), .tc(div_tc)
  );

  assign synth_out = acc_run ? acc_msb : div_out;
  assign synth_stb = stb_q;
  assign chan_err  = err_q;

  // R11: strobe is a single-cycle pulse
  p_stb_single_r11: assert property (@(posedge clk) disable iff (!rst_s)
    synth_stb |=> !synth_stb);

  // R6 and R7: the active setting moves only at a period boundary
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_s)
    !bnd |=> ($stable(ch_q) && $stable(mode_q)));

  // R8: the active channel stays inside the grid
  p_ch_in_grid_r8: assert property (@(posedge clk) disable iff (!rst_s)
    ch_q <= CH_MAX);

  // R9: the error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_s)
    chan_err |=> chan_err);

endmodule

// File: tb/chan_clk_synth_bench.sv
`timescale 1ns/1ps
module chan_clk_synth_bench;

  localparam longint unsigned M_HZ = 64'd100_000_000;
  localparam int WIN = 3000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] chan_sel;
  logic       mode_sel;
  logic       synth_out, synth_stb, chan_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  chan_clk_synth u_chan_clk_synth (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .mode_sel(mode_sel),
    .synth_out(synth_out), .synth_stb(synth_stb), .chan_err(chan_err)
  );

  function automatic longint unsigned f_of(int k);
    return 64'd8_000_000 + 64'd100_000 * 64'(k);
  endfunction

  function automatic longint unsigned tw_of(int k);
    return ((f_of(k) << 32) + M_HZ / 2) / M_HZ;
  endfunction

  function automatic int d_of(int k);
    return int'((M_HZ + f_of(k) / 2) / f_of(k));
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_stb();
    do @(negedge clk); while (!synth_stb);
  endtask

  // Called on a strobe sample; returns the period and high samples in it.
  task automatic measure(output int n, output int hi);
    n  = 1;
    hi = int'(synth_out);
    forever begin
      @(negedge clk);
      if (synth_stb) break;
      n++;
      hi += int'(synth_out);
    end
  endtask

  task automatic check_acc_period(int k, int n, string req);
    longint unsigned lo;
    longint unsigned up;
    lo = (64'd1 << 32) / tw_of(k);
    up = lo + ((((64'd1 << 32) % tw_of(k)) != 0) ? 1 : 0);
    check((n == int'(lo)) || (n == int'(up)), req, n, longint'(lo));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int n, hi, cnt;
    real expc;
    rst_n    = 1'b0;
    chan_sel = 5'd0;
    mode_sel = 1'b0;
    repeat (5) @(negedge clk);
    // R10: reset state
    check(synth_out == 1'b0, "R10 out in reset", synth_out, 0);
    check(synth_stb == 1'b0, "R10 stb in reset", synth_stb, 0);
    check(chan_err  == 1'b0, "R10 err in reset", chan_err, 0);
    rst_n = 1'b1;

    // R10: default runs channel 0 in accumulator mode
    wait_stb();
    measure(n, hi);
    check_acc_period(0, n, "R10 default channel 0 accumulator");

    // R1 R2 R3: accumulator sweep
    for (int k = 0; k < 21; k++) begin
      chan_sel = 5'(k);
      repeat (3) wait_stb();
      for (int j = 0; j < 4; j++) begin
        measure(n, hi);
        check_acc_period(k, n, "R3 accumulator period");
        check(n >= 2, "R11 strobe spacing", n, 2);
      end
      cnt = 0;
      for (int c = 0; c < WIN; c++) begin
        @(negedge clk);
        cnt += int'(synth_stb);
      end
      expc = real'(WIN) * real'(f_of(k)) / real'(M_HZ);
      check((real'(cnt) - expc <= 1.0) && (expc - real'(cnt) <= 1.0),
            "R1/R2 average rate", cnt, longint'(expc));
    end

    // R4 R5: divider sweep
    mode_sel = 1'b1;
    for (int k = 0; k < 21; k++) begin
      chan_sel = 5'(k);
      repeat (3) wait_stb();
      for (int j = 0; j < 2; j++) begin
        measure(n, hi);
        check(n == d_of(k), "R4 divider period", n, d_of(k));
        check(hi == d_of(k) / 2, "R5 divider high time", hi, d_of(k) / 2);
      end
    end

    // R6: channel change waits for the boundary
    chan_sel = 5'd0;
    repeat (3) wait_stb();
    chan_sel = 5'd20;
    measure(n, hi);
    check(n == 13, "R6 old period completes", n, 13);
    measure(n, hi);
    check(n == 10, "R6 new period applied", n, 10);

    // R7: mode change waits for the boundary, new engine from zero phase
    mode_sel = 1'b0;
    measure(n, hi);
    check(n == 10, "R7 divider period completes", n, 10);
    measure(n, hi);
    check(n == 10, "R7 accumulator first period from zero", n, 10);
    mode_sel = 1'b1;
    repeat (3) wait_stb();

    // R8 R9: out-of-range index
    check(chan_err == 1'b0, "R9 flag clear before error", chan_err, 0);
    chan_sel = 5'd0;
    repeat (3) wait_stb();
    chan_sel = 5'd31;
    repeat (3) wait_stb();
    measure(n, hi);
    check(n == 10, "R8 clamped to channel 20", n, 10);
    check(hi == 5, "R8 clamped high time", hi, 5);
    check(chan_err == 1'b1, "R9 flag set", chan_err, 1);
    chan_sel = 5'd3;
    repeat (3) wait_stb();
    measure(n, hi);
    check(n == d_of(3), "R8 recovery channel 3", n, d_of(3));
    check(chan_err == 1'b1, "R9 flag sticky", chan_err, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule